// File: doc/BRIEF.md
# Halt-Driven Low-Power Mode Controller

This block sits beside a small processor core and chooses the low-power state the core enters when it executes a halt. On the halt strobe it samples an idle-enable bit, a keep-system-clock bit, the watchdog and brown-out detector enables, and the watchdog clock-source select. From these it picks one of four low-power modes. Each mode fixes which of the three clock-gate enables stay asserted: system clock, time-base clock and low-speed subclock.

The block also produces the watchdog side effects of entering a mode. It issues a clear pulse on entry and drives a count-enable that shows whether the watchdog can keep counting. That depends on the mode and on which clock feeds the watchdog. Two sticky status flags record power-down and watchdog timeout for software. A wake-up request from any low-power mode returns the controller to the running state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode indicator shows RUN (bit 0 of `mode_oh_o`), all three clock enables are 1, `wdt_clr_o` is 0 and both status flags are 0.
- R2: A halt in RUN with idle-enable 0 and both watchdog and detector enables 0 enters SLEEP0 (bit 1 of `mode_oh_o`) on the next cycle, with all three clock enables at 0.
- R3: A halt with idle-enable 0 and at least one of watchdog or detector enabled enters SLEEP1 (bit 2). System and time-base enables are 0 and the subclock enable is 1.
- R4: A halt with idle-enable 1 and keep-system-clock 0 enters IDLE0 (bit 3). The system enable is 0 and the time-base and subclock enables are 1.
- R5: A halt with idle-enable 1 and keep-system-clock 1 enters IDLE1 (bit 4), with all three clock enables held at 1.
- R6: Entry into any low-power mode sets `pd_flag_o` and clears `to_flag_o` in the same cycle. A timeout strobe in RUN sets `to_flag_o`. `pd_flag_o` stays set through wake-up until `pd_clr_i` clears it.
- R7: Entry with the watchdog enabled raises `wdt_clr_o` for `WDT_CLR_LEN` cycles (default 1), starting on the cycle the mode changes. Entry with the watchdog disabled produces no pulse.
- R8: In a low-power mode `wdt_cnt_en_o` is the sampled watchdog enable ANDed with the condition that its clock runs. In SLEEP1 and IDLE0 the watchdog counts only when `wdt_src_sub_i` (1 = subclock) was 1. In IDLE1 it counts from either source. In SLEEP0 it is 0. In RUN it follows `wdt_en_i`.
- R9: `wake_i` in any low-power mode returns the controller to RUN on the next cycle, with all clock enables at 1.
- R10: While in a low-power mode, further halt strobes and changes to the control bits, enables or source select have no effect on the mode or on `wdt_cnt_en_o`.
- R11: In RUN, `wake_i` has no effect. A halt is the only way to leave RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | One-cycle strobe from the core when a halt executes |
| idle_en_i | input | 1 | 1 selects an idle mode, 0 a sleep mode |
| keep_sys_i | input | 1 | In idle, 1 keeps the system clock running |
| wdt_en_i | input | 1 | Watchdog enabled |
| lvd_en_i | input | 1 | Low-voltage detector enabled |
| wdt_src_sub_i | input | 1 | Watchdog clock source: 1 subclock, 0 system clock |
| wake_i | input | 1 | Wake-up request |
| wdt_tmo_i | input | 1 | Watchdog timeout strobe, sets the timeout flag |
| pd_clr_i | input | 1 | Software clear of the power-down flag |
| sys_clk_en_o | output | 1 | System clock gate enable |
| tb_clk_en_o | output | 1 | Time-base clock gate enable |
| sub_clk_en_o | output | 1 | Subclock gate enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| wdt_cnt_en_o | output | 1 | Watchdog may count |
| pd_flag_o | output | 1 | Power-down status flag |
| to_flag_o | output | 1 | Watchdog timeout status flag |
| mode_oh_o | output | 5 | One-hot mode: bit0 RUN, bit1 SLEEP0, bit2 SLEEP1, bit3 IDLE0, bit4 IDLE1 |

## Verification
A wrong decode at halt time shows one cycle after the strobe. It appears at once in the one-hot indicator and in the three clock enables, and the bench compares both against every combination of control bits. A state register that ignores wake-up or accepts a second halt leaves the indicator frozen or moved on the next cycle. A wrongly latched watchdog source or enable can show only in `wdt_cnt_en_o`. So the bench changes the live inputs during a low-power mode and checks that this output holds. Flag faults show in the cycle after entry, and a missing hold shows after wake-up.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   localparam int PM_NUM_MODES = 5;
   localparam int PM_MODE_W    = $clog2(PM_NUM_MODES);

   typedef enum logic [PM_MODE_W-1:0] {
      PM_RUN  = 3'd0,
      PM_SLP0 = 3'd1,
      PM_SLP1 = 3'd2,
      PM_IDL0 = 3'd3,
      PM_IDL1 = 3'd4
   } pm_mode_e;

   typedef struct packed {
      logic sys;
      logic tb;
      logic sub;
   } pm_gates_t;

   localparam pm_gates_t PM_GATES_ALL_ON = '{sys: 1'b1, tb: 1'b1, sub: 1'b1};

endpackage

// File: rtl/pmc_mode_sel.sv
module pmc_mode_sel
   import pwr_mode_pkg::*;
(
   input  logic     idle_en_i,
   input  logic     keep_sys_i,
   input  logic     wdt_en_i,
   input  logic     lvd_en_i,
   output pm_mode_e mode_o
);

   always_comb begin
      if (idle_en_i) begin
         mode_o = keep_sys_i ? PM_IDL1 : PM_IDL0;
      end else begin
         mode_o = (wdt_en_i || lvd_en_i) ? PM_SLP1 : PM_SLP0;
      end
   end

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pwr_mode_pkg::*;
#(
   parameter int WDT_CLR_LEN = 1
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     halt_i,
   input  logic     wake_i,
   input  pm_mode_e next_mode_i,
   input  logic     wdt_en_i,
   input  logic     wdt_src_sub_i,
   output pm_mode_e mode_o,
   output logic     enter_o,
   output logic     wdt_en_q_o,
   output logic     wdt_sub_q_o,
   output logic     wdt_clr_o
);

   localparam int CW = $clog2(WDT_CLR_LEN + 1);

   initial begin
      assert (WDT_CLR_LEN >= 1 && WDT_CLR_LEN <= 255)
         else $error("pmc_seq: WDT_CLR_LEN out of range");
   end

   pm_mode_e        mode_q;
   logic            wdt_en_q;
   logic            wdt_sub_q;
   logic [CW-1:0]   clr_cnt_q;
   logic            in_lp;

   assign in_lp   = (mode_q != PM_RUN);
   assign enter_o = halt_i && !in_lp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= PM_RUN;
         wdt_en_q  <= 1'b0;
         wdt_sub_q <= 1'b0;
      end else if (enter_o) begin
         mode_q    <= next_mode_i;
         wdt_en_q  <= wdt_en_i;
         wdt_sub_q <= wdt_src_sub_i;
      end else if (in_lp && wake_i) begin
         mode_q    <= PM_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_cnt_q <= '0;
      end else if (enter_o && wdt_en_i) begin
         clr_cnt_q <= CW'(WDT_CLR_LEN);
      end else if (clr_cnt_q != '0) begin
         clr_cnt_q <= clr_cnt_q - 1'b1;
      end
   end

   assign mode_o      = mode_q;
   assign wdt_en_q_o  = wdt_en_q;
   assign wdt_sub_q_o = wdt_sub_q;
   assign wdt_clr_o   = (clr_cnt_q != '0);

   AST_CLR_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_clr_o) |-> $past(enter_o && wdt_en_i)); // R7
   AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp && !wake_i) |=> $stable(mode_q)); // R10
   AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp && wake_i) |=> (mode_q == PM_RUN)); // R9
   AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_lp && !halt_i) |=> (mode_q == PM_RUN)); // R11

endmodule

// File: rtl/pmc_gate_map.sv
module pmc_gate_map
   import pwr_mode_pkg::*;
#(
   parameter bit REG_GATES = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  pm_mode_e                mode_i,
   input  logic                    wdt_en_live_i,
   input  logic                    wdt_en_q_i,
   input  logic                    wdt_sub_q_i,
   output pm_gates_t               gates_o,
   output logic                    wdt_cnt_en_o,
   output logic [PM_NUM_MODES-1:0] mode_oh_o
);

   pm_gates_t gates_n;
   logic      cnt_n;

   always_comb begin
      gates_n = PM_GATES_ALL_ON;
      cnt_n   = wdt_en_live_i;
      case (mode_i)
         PM_SLP0: begin
            gates_n = '{sys: 1'b0, tb: 1'b0, sub: 1'b0};
            cnt_n   = 1'b0;
         end
         PM_SLP1: begin
            gates_n = '{sys: 1'b0, tb: 1'b0, sub: 1'b1};
            cnt_n   = wdt_en_q_i && wdt_sub_q_i;
         end
         PM_IDL0: begin
            gates_n = '{sys: 1'b0, tb: 1'b1, sub: 1'b1};
            cnt_n   = wdt_en_q_i && wdt_sub_q_i;
         end
         PM_IDL1: begin
            gates_n = PM_GATES_ALL_ON;
            cnt_n   = wdt_en_q_i;
         end
         default: begin
            gates_n = PM_GATES_ALL_ON;
            cnt_n   = wdt_en_live_i;
         end
      endcase
   end

   for (genvar i = 0; i < PM_NUM_MODES; i++) begin : g_oh
      assign mode_oh_o[i] = (mode_i == pm_mode_e'(PM_MODE_W'(i)));
   end

   if (REG_GATES) begin : g_reg
      pm_gates_t gates_q;
      logic      cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gates_q <= PM_GATES_ALL_ON;
            cnt_q   <= 1'b0;
         end else begin
            gates_q <= gates_n;
            cnt_q   <= cnt_n;
         end
      end
      assign gates_o      = gates_q;
      assign wdt_cnt_en_o = cnt_q;
   end else begin : g_comb
      assign gates_o      = gates_n;
      assign wdt_cnt_en_o = cnt_n;

      AST_SLEEP0_DARK: assert property (@(posedge clk) disable iff (!rst_n)
         mode_oh_o[1] |-> (gates_o == '0)); // R2
      AST_IDLE1_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
         mode_oh_o[4] |-> (gates_o == PM_GATES_ALL_ON)); // R5
      AST_SYS_OFF_LP: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_oh_o[2] || mode_oh_o[3]) |-> !gates_o.sys); // R3
   end

endmodule

// File: rtl/pmc_flags.sv
module pmc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic pd_clr_i,
   input  logic tmo_i,
   output logic pd_o,
   output logic to_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_o <= 1'b0;
      end else if (enter_i) begin
         pd_o <= 1'b1;
      end else if (pd_clr_i) begin
         pd_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_o <= 1'b0;
      end else if (enter_i) begin
         to_o <= 1'b0;
      end else if (tmo_i) begin
         to_o <= 1'b1;
      end
   end

   AST_PD_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> pd_o); // R6
   AST_TO_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> !to_o); // R6
   AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_o && !pd_clr_i) |=> pd_o); // R6

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int WDT_CLR_LEN = 1,
   parameter bit REG_GATES   = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_i,
   input  logic       idle_en_i,
   input  logic       keep_sys_i,
   input  logic       wdt_en_i,
   input  logic       lvd_en_i,
   input  logic       wdt_src_sub_i,
   input  logic       wake_i,
   input  logic       wdt_tmo_i,
   input  logic       pd_clr_i,
   output logic       sys_clk_en_o,
   output logic       tb_clk_en_o,
   output logic       sub_clk_en_o,
   output logic       wdt_clr_o,
   output logic       wdt_cnt_en_o,
   output logic       pd_flag_o,
   output logic       to_flag_o,
   output logic [4:0] mode_oh_o
);

   initial begin
      assert (PM_NUM_MODES == 5) else $error("pwr_mode_ctrl: mode count mismatch");
   end

   pm_mode_e  next_mode;
   pm_mode_e  cur_mode;
   logic      enter;
   logic      wdt_en_q;
   logic      wdt_sub_q;
   pm_gates_t gates;

   pmc_mode_sel u_sel (
      .idle_en_i  (idle_en_i),
      .keep_sys_i (keep_sys_i),
      .wdt_en_i   (wdt_en_i),
      .lvd_en_i   (lvd_en_i),
      .mode_o     (next_mode)
   );

   pmc_seq #(.WDT_CLR_LEN(WDT_CLR_LEN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt_i        (halt_i),
      .wake_i        (wake_i),
      .next_mode_i   (next_mode),
      .wdt_en_i      (wdt_en_i),
      .wdt_src_sub_i (wdt_src_sub_i),
      .mode_o        (cur_mode),
      .enter_o       (enter),
      .wdt_en_q_o    (wdt_en_q),
      .wdt_sub_q_o   (wdt_sub_q),
      .wdt_clr_o     (wdt_clr_o)
   );

   pmc_gate_map #(.REG_GATES(REG_GATES)) u_map (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_i        (cur_mode),
      .wdt_en_live_i (wdt_en_i),
      .wdt_en_q_i    (wdt_en_q),
      .wdt_sub_q_i   (wdt_sub_q),
      .gates_o       (gates),
      .wdt_cnt_en_o  (wdt_cnt_en_o),
      .mode_oh_o     (mode_oh_o)
   );

   pmc_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter_i  (enter),
      .pd_clr_i (pd_clr_i),
      .tmo_i    (wdt_tmo_i),
      .pd_o     (pd_flag_o),
      .to_o     (to_flag_o)
   );

   assign sys_clk_en_o = gates.sys;
   assign tb_clk_en_o  = gates.tb;
   assign sub_clk_en_o = gates.sub;

   AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(mode_oh_o)); // R1
   AST_WAKE_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh_o[0] && !halt_i) |=> mode_oh_o[0]); // R11

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt_i = 0, idle_en_i = 0, keep_sys_i = 0, wdt_en_i = 0;
   logic       lvd_en_i = 0, wdt_src_sub_i = 0, wake_i = 0, wdt_tmo_i = 0, pd_clr_i = 0;
   logic       sys_clk_en_o, tb_clk_en_o, sub_clk_en_o, wdt_clr_o, wdt_cnt_en_o;
   logic       pd_flag_o, to_flag_o;
   logic [4:0] mode_oh_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwr_mode_ctrl u_pwr_mode_ctrl (.*);

   // [14]idle [13]keep [12]wdt [11]lvd [10]src | [9:5]mode_oh [4:2]sys,tb,sub [1]clr [0]cnt
   localparam logic [14:0] VEC [8] = '{
      {5'b00000, 5'b00010, 3'b000, 1'b0, 1'b0},  // R2 SLEEP0
      {5'b01011, 5'b00100, 3'b001, 1'b0, 1'b0},  // R3 SLEEP1 via detector
      {5'b00101, 5'b00100, 3'b001, 1'b1, 1'b1},  // R3 SLEEP1 wdt on subclock
      {5'b00100, 5'b00100, 3'b001, 1'b1, 1'b0},  // R3 SLEEP1 wdt on sysclk
      {5'b10101, 5'b01000, 3'b011, 1'b1, 1'b1},  // R4 IDLE0 wdt on subclock
      {5'b10100, 5'b01000, 3'b011, 1'b1, 1'b0},  // R4 IDLE0 wdt frozen
      {5'b11100, 5'b10000, 3'b111, 1'b1, 1'b1},  // R5 IDLE1 wdt on sysclk
      {5'b11010, 5'b10000, 3'b111, 1'b0, 1'b0}   // R5 IDLE1 wdt off
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic [4:0] c);
      {idle_en_i, keep_sys_i, wdt_en_i, lvd_en_i, wdt_src_sub_i} = c;
   endtask

   task automatic do_halt();
      halt_i = 1'b1;
      tick();
      halt_i = 1'b0;
   endtask

   task automatic do_wake();
      wake_i = 1'b1;
      tick();
      wake_i = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode_oh_o, 5'b00001);
      chk("R1 gates", {sys_clk_en_o, tb_clk_en_o, sub_clk_en_o}, 3'b111);
      chk("R1 clr", wdt_clr_o, 0);
      chk("R1 flags", {pd_flag_o, to_flag_o}, 2'b00);

      for (int v = 0; v < 8; v++) begin
         set_cfg(VEC[v][14:10]);
         wdt_tmo_i = 1'b1;
         tick();
         wdt_tmo_i = 1'b0;
         chk("R6 to set", to_flag_o, 1);
         do_halt();
         chk("R2-R5 mode", mode_oh_o, VEC[v][9:5]);
         chk("R2-R5 gates", {sys_clk_en_o, tb_clk_en_o, sub_clk_en_o}, VEC[v][4:2]);
         chk("R7 clr", wdt_clr_o, VEC[v][1]);
         chk("R8 cnt", wdt_cnt_en_o, VEC[v][0]);
         chk("R6 flags", {pd_flag_o, to_flag_o}, 2'b10);
         tick();
         chk("R7 clr one cycle", wdt_clr_o, 0);
         do_wake();
         chk("R9 mode", mode_oh_o, 5'b00001);
         chk("R9 gates", {sys_clk_en_o, tb_clk_en_o, sub_clk_en_o}, 3'b111);
         chk("R6 pd held", pd_flag_o, 1);
         pd_clr_i = 1'b1;
         tick();
         pd_clr_i = 1'b0;
         chk("R6 pd cleared", pd_flag_o, 0);
      end

      // R11: wake in RUN is ignored
      set_cfg(5'b10000);
      do_wake();
      tick();
      chk("R11 wake in run", mode_oh_o, 5'b00001);
      chk("R11 pd untouched", pd_flag_o, 0);

      // R8: RUN follows live watchdog enable
      wdt_en_i = 1'b1;
      #1;
      chk("R8 run live", wdt_cnt_en_o, 1);
      wdt_en_i = 1'b0;
      #1;
      chk("R8 run live off", wdt_cnt_en_o, 0);

      // R10: IDLE0 with subclock watchdog, then disturb all inputs
      set_cfg(5'b10101);
      do_halt();
      chk("R10 entered", mode_oh_o, 5'b01000);
      set_cfg(5'b01000);
      do_halt();
      chk("R10 mode held", mode_oh_o, 5'b01000);
      chk("R10 cnt held", wdt_cnt_en_o, 1);
      chk("R10 gates held", {sys_clk_en_o, tb_clk_en_o, sub_clk_en_o}, 3'b011);
      set_cfg(5'b11000);
      tick();
      chk("R10 idle1 bits ignored", mode_oh_o, 5'b01000);
      do_wake();
      chk("R9 back to run", mode_oh_o, 5'b00001);

      // R7: entry with watchdog disabled gives no pulse (SLEEP1 via detector)
      set_cfg(5'b00010);
      do_halt();
      chk("R3 sleep1 lvd", mode_oh_o, 5'b00100);
      chk("R7 no pulse", wdt_clr_o, 0);
      do_wake();

      // R6: halt while timeout strobe active, entry wins
      set_cfg(5'b11100);
      wdt_tmo_i = 1'b1;
      do_halt();
      wdt_tmo_i = 1'b0;
      chk("R6 to cleared on entry", to_flag_o, 0);
      chk("R5 idle1", mode_oh_o, 5'b10000);
      do_wake();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule